// File: doc/BRIEF.md
# VME A24/D16 Slave Address Decoder

This block terminates word-wide VME slave cycles that use 24-bit addressing on a card carrying eight internal devices. It checks the address modifier and the slot number, then splits the address into a one-hot device-select field and a register index. These drive a small internal bus with a register address, a write/read level, write data, read data and one active-low enable per device.

Several device-select bits may be set in one write, so a single cycle can load the same register in many devices. A write sent to the all-ones slot number reaches every card in the crate. Both features shorten table downloads. Reads always target exactly one device on this card. After a fixed wait the block acknowledges the cycle and holds the acknowledge until the master lifts both data strobes.

Top module: `vme_slave_decode`

## Requirements
- R1: A cycle is taken only when the address modifier is one of 0x39, 0x3A, 0x3B, 0x3D, 0x3E or 0x3F. For any other code, no enable goes low and DTACK stays high.
- R2: For a normal access, address bits 23..19 must equal `geo_addr`. On a mismatch the cycle is ignored.
- R3: Address bits 18..11 form the device field. Address bit 11+i set drives `bus_ce_n[i]` low for the whole cycle.
- R4: Address bits 10..1 appear on `bus_addr`. `bus_wr` is 1 for a write (`vme_write_n` low) and 0 for a read. On a write, `bus_wdata` carries the data that was on `vme_data_in` at the qualifying edge.
- R5: A write with several device bits set asserts every selected enable at once.
- R6: A read with more than one device bit set is rejected: no enable goes low and there is no DTACK.
- R7: Address bits 23..19 all ones mark a crate-wide write that is accepted whatever `geo_addr` holds. A read to that slot number is rejected.
- R8: DTACK goes low on the third rising edge after the qualifying edge. For a read, `vme_data_out` then holds the selected device's `bus_rdata` and `vme_data_oe` is high until the cycle ends.
- R9: DTACK stays low while either data strobe is low. On the first rising edge that sees both strobes high, DTACK goes high and all enables go high together.
- R10: A cycle qualifies only when AS is low and both data strobes are low, with a nonzero device field. A cycle with one strobe low, or with no device bit set, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| geo_addr | input | 5 | Slot number of this card |
| vme_am | input | 6 | Address modifier |
| vme_addr | input | 23 | Address bits 23..1 |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 2 | Data strobes, active low |
| vme_write_n | input | 1 | Low for write, high for read |
| vme_data_in | input | 16 | Write data from the backplane |
| vme_data_out | output | 16 | Read data to the backplane |
| vme_data_oe | output | 1 | Read data drive enable |
| vme_dtack_n | output | 1 | Data acknowledge, active low |
| bus_addr | output | 10 | Internal register index |
| bus_wr | output | 1 | Internal write (1) / read (0) |
| bus_wdata | output | 16 | Internal write data |
| bus_rdata | input | 16 | Internal read data from the selected device |
| bus_ce_n | output | 8 | Per-device enables, active low |

## Verification
The qualifying edge is the first rising edge that sees AS and both data strobes low. The enables, `bus_addr`, `bus_wr` and `bus_wdata` change just after that edge. DTACK and read data follow three edges later, and everything returns to idle one edge after both strobes rise. The bench drives inputs just after rising edges and samples on falling edges. It counts falling edges from the first one that shows an enable low, and expects DTACK at count 3. Each cycle's fields are compared when the enables return high. Rejected cycles are checked by holding the strobes for twelve clocks and confirming that no enable and no DTACK appeared.

// File: rtl/vme_dec_pkg.sv
`timescale 1ns/1ps
package vme_dec_pkg;
  localparam int N_AM = 6;
  localparam logic [5:0] AM_TABLE [N_AM] = '{6'h39, 6'h3A, 6'h3B, 6'h3D, 6'h3E, 6'h3F};

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_WAIT = 2'd1,
    CYC_ACK  = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/vme_addr_match.sv
`timescale 1ns/1ps
module vme_addr_match #(
  parameter int GA_W   = 5,
  parameter int CHIP_N = 8,
  parameter int REG_W  = 10,
  localparam int ADDR_HI = GA_W + CHIP_N + REG_W
) (
  input  logic [ADDR_HI:1]  addr_i,
  input  logic [5:0]        am_i,
  input  logic [GA_W-1:0]   geo_i,
  input  logic              write_i,
  output logic              am_ok_o,
  output logic              accept_o,
  output logic [CHIP_N-1:0] chip_sel_o,
  output logic [REG_W-1:0]  reg_idx_o
);
  import vme_dec_pkg::*;

  logic [N_AM-1:0]   am_hit;
  logic [GA_W-1:0]   slot_field;
  logic [CHIP_N-1:0] chip_field;
  logic              crate_wide;
  logic              own_slot;
  logic              multi_chip;
  logic              write_ok;
  logic              read_ok;

  for (genvar g = 0; g < N_AM; g++) begin : g_am
    assign am_hit[g] = (am_i == AM_TABLE[g]);
  end

  assign slot_field = addr_i[ADDR_HI -: GA_W];
  assign chip_field = addr_i[REG_W+CHIP_N -: CHIP_N];
  assign reg_idx_o  = addr_i[REG_W:1];
  assign chip_sel_o = chip_field;

  always_comb begin
    am_ok_o    = |am_hit;
    crate_wide = &slot_field;
    own_slot   = (slot_field == geo_i);
    multi_chip = (chip_field & (chip_field - CHIP_N'(1))) != '0;
    write_ok   = own_slot | crate_wide;
    read_ok    = own_slot & ~crate_wide & ~multi_chip;
    accept_o   = am_ok_o & (|chip_field) & (write_i ? write_ok : read_ok);
  end
endmodule

// File: rtl/vme_cycle_fsm.sv
`timescale 1ns/1ps
module vme_cycle_fsm #(
  parameter int CHIP_N    = 8,
  parameter int REG_W     = 10,
  parameter int DATA_W    = 16,
  parameter int ACK_DELAY = 3,
  localparam int CNT_W = (ACK_DELAY > 1) ? $clog2(ACK_DELAY) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_on_i,
  input  logic              strobe_off_i,
  input  logic              accept_i,
  input  logic              write_i,
  input  logic [CHIP_N-1:0] chip_sel_i,
  input  logic [REG_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [CHIP_N-1:0] ce_n_o,
  output logic [REG_W-1:0]  addr_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              dtack_n_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_oe_o
);
  import vme_dec_pkg::*;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 1);

  cyc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CHIP_N-1:0] ce_n_q, ce_n_d;
  logic              dtack_n_q, dtack_n_d;
  logic              rd_oe_q, rd_oe_d;
  logic              cap_en, rd_cap_en;
  logic [REG_W-1:0]  addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    ce_n_d    = ce_n_q;
    dtack_n_d = dtack_n_q;
    rd_oe_d   = rd_oe_q;
    cap_en    = 1'b0;
    rd_cap_en = 1'b0;
    case (state_q)
      CYC_IDLE: begin
        if (strobe_on_i && accept_i) begin
          state_d = CYC_WAIT;
          cnt_d   = '0;
          ce_n_d  = ~chip_sel_i;
          cap_en  = 1'b1;
        end
      end
      CYC_WAIT: begin
        if (strobe_off_i) begin
          state_d = CYC_IDLE;
          ce_n_d  = '1;
        end else if (cnt_q == CNT_LAST) begin
          state_d   = CYC_ACK;
          dtack_n_d = 1'b0;
          rd_oe_d   = ~wr_q;
          rd_cap_en = ~wr_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CYC_ACK: begin
        if (strobe_off_i) begin
          state_d   = CYC_IDLE;
          ce_n_d    = '1;
          dtack_n_d = 1'b1;
          rd_oe_d   = 1'b0;
        end
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CYC_IDLE;
      cnt_q     <= '0;
      ce_n_q    <= '1;
      dtack_n_q <= 1'b1;
      rd_oe_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      ce_n_q    <= ce_n_d;
      dtack_n_q <= dtack_n_d;
      rd_oe_q   <= rd_oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (cap_en) begin
      addr_q  <= reg_idx_i;
      wr_q    <= write_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_cap_en) begin
      rdata_q <= rdata_i;
    end
  end

  assign ce_n_o    = ce_n_q;
  assign addr_o    = addr_q;
  assign wr_o      = wr_q;
  assign wdata_o   = wdata_q;
  assign dtack_n_o = dtack_n_q;
  assign rdata_o   = rdata_q;
  assign rd_oe_o   = rd_oe_q;

  assert_ack_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CYC_ACK && !strobe_off_i) |=> !dtack_n_q);

  assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CYC_ACK && strobe_off_i) |=> (dtack_n_q && (&ce_n_q)));

  assert_oe_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe_q |-> (!wr_q && !dtack_n_q));
endmodule

// File: rtl/vme_slave_decode.sv
`timescale 1ns/1ps
module vme_slave_decode #(
  parameter int GA_W      = 5,
  parameter int CHIP_N    = 8,
  parameter int REG_W     = 10,
  parameter int DATA_W    = 16,
  parameter int ACK_DELAY = 3,
  localparam int ADDR_HI = GA_W + CHIP_N + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GA_W-1:0]   geo_addr,
  input  logic [5:0]        vme_am,
  input  logic [ADDR_HI:1]  vme_addr,
  input  logic              vme_as_n,
  input  logic [1:0]        vme_ds_n,
  input  logic              vme_write_n,
  input  logic [DATA_W-1:0] vme_data_in,
  output logic [DATA_W-1:0] vme_data_out,
  output logic              vme_data_oe,
  output logic              vme_dtack_n,
  output logic [REG_W-1:0]  bus_addr,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [CHIP_N-1:0] bus_ce_n
);
  localparam int AGE_W = $clog2(ACK_DELAY + 2) + 1;
  localparam logic [AGE_W-1:0] AGE_TGT = AGE_W'(ACK_DELAY);

  logic              strobe_on, strobe_off;
  logic              am_ok, accept;
  logic [CHIP_N-1:0] chip_sel;
  logic [REG_W-1:0]  reg_idx;
  logic              ce_idle;

  assign strobe_on  = ~vme_as_n & (vme_ds_n == 2'b00);
  assign strobe_off = (vme_ds_n == 2'b11);

  vme_addr_match #(
    .GA_W(GA_W), .CHIP_N(CHIP_N), .REG_W(REG_W)
  ) u_match (
    .addr_i     (vme_addr),
    .am_i       (vme_am),
    .geo_i      (geo_addr),
    .write_i    (~vme_write_n),
    .am_ok_o    (am_ok),
    .accept_o   (accept),
    .chip_sel_o (chip_sel),
    .reg_idx_o  (reg_idx)
  );

  vme_cycle_fsm #(
    .CHIP_N(CHIP_N), .REG_W(REG_W), .DATA_W(DATA_W), .ACK_DELAY(ACK_DELAY)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_on_i  (strobe_on),
    .strobe_off_i (strobe_off),
    .accept_i     (accept),
    .write_i      (~vme_write_n),
    .chip_sel_i   (chip_sel),
    .reg_idx_i    (reg_idx),
    .wdata_i      (vme_data_in),
    .rdata_i      (bus_rdata),
    .ce_n_o       (bus_ce_n),
    .addr_o       (bus_addr),
    .wr_o         (bus_wr),
    .wdata_o      (bus_wdata),
    .dtack_n_o    (vme_dtack_n),
    .rdata_o      (vme_data_out),
    .rd_oe_o      (vme_data_oe)
  );

  assign ce_idle = &bus_ce_n;

  // checker counter: clocks since the enables went active
  logic [AGE_W-1:0] sel_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sel_age <= '0;
    else if (ce_idle)        sel_age <= '0;
    else if (sel_age != '1)  sel_age <= sel_age + 1'b1;
  end

  assert_dtack_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vme_dtack_n) |-> (sel_age == AGE_TGT));

  assert_read_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_idle && !bus_wr) |-> $onehot(~bus_ce_n));

  assert_ack_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vme_dtack_n |-> !ce_idle);

  assert_am_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_idle) |-> $past(am_ok));

  assert_ce_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_idle && $past(!ce_idle)) |-> $stable(bus_ce_n));
endmodule

// File: tb/tb_vme_slave_decode.sv
`timescale 1ns/1ps
module tb_vme_slave_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  geo_addr = 5'h0B;
  logic [5:0]  vme_am = 6'h00;
  logic [23:1] vme_addr = '0;
  logic        vme_as_n = 1'b1;
  logic [1:0]  vme_ds_n = 2'b11;
  logic        vme_write_n = 1'b1;
  logic [15:0] vme_data_in = '0;
  logic [15:0] vme_data_out;
  logic        vme_data_oe;
  logic        vme_dtack_n;
  logic [9:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  bus_ce_n;

  always #2.5 clk = ~clk;

  vme_slave_decode dut (
    .clk(clk), .rst_n(rst_n), .geo_addr(geo_addr), .vme_am(vme_am),
    .vme_addr(vme_addr), .vme_as_n(vme_as_n), .vme_ds_n(vme_ds_n),
    .vme_write_n(vme_write_n), .vme_data_in(vme_data_in),
    .vme_data_out(vme_data_out), .vme_data_oe(vme_data_oe),
    .vme_dtack_n(vme_dtack_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ce_n(bus_ce_n)
  );

  function automatic logic [15:0] dev_model(logic [7:0] ce_n, logic [9:0] a);
    return {ce_n, 8'h00} ^ {6'h00, a};
  endfunction
  assign bus_rdata = (&bus_ce_n) ? 16'h0000 : dev_model(bus_ce_n, bus_addr);

  typedef struct {
    logic [7:0]  ce_n;
    logic [9:0]  addr;
    logic        wr;
    logic [15:0] data;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails = 0;
  int act_cycles = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor: observe cycles on the internal bus and retire expected items
  logic        in_cyc = 1'b0;
  bit          acked;
  int          age, ack_age;
  logic [7:0]  ce_cap;
  logic [9:0]  a_cap;
  logic        wr_cap, oe_cap;
  logic [15:0] wd_cap, rd_cap;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_cyc && !(&bus_ce_n)) begin
        in_cyc = 1'b1; age = 0; acked = 1'b0; ack_age = -1;
        ce_cap = bus_ce_n; a_cap = bus_addr; wr_cap = bus_wr; wd_cap = bus_wdata;
        act_cycles++;
      end else if (in_cyc && !(&bus_ce_n)) begin
        age++;
      end
      if (in_cyc && !acked && !vme_dtack_n) begin
        acked = 1'b1; ack_age = age; rd_cap = vme_data_out; oe_cap = vme_data_oe;
      end
      if (in_cyc && (&bus_ce_n)) begin
        in_cyc = 1'b0;
        chk(vme_dtack_n == 1'b1, "R9", "dtack released with enables", 32'(vme_dtack_n), 32'h1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected bus cycle", 32'(ce_cap), 32'hFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(ce_cap == e.ce_n, {e.req, " R3"}, "enables", 32'(ce_cap), 32'(e.ce_n));
          chk(a_cap == e.addr, {e.req, " R4"}, "register index", 32'(a_cap), 32'(e.addr));
          chk(wr_cap == e.wr, {e.req, " R4"}, "write level", 32'(wr_cap), 32'(e.wr));
          chk(ack_age == 3, {e.req, " R8"}, "dtack delay", 32'(ack_age), 32'd3);
          if (e.wr) begin
            chk(wd_cap == e.data, {e.req, " R4"}, "write data", 32'(wd_cap), 32'(e.data));
          end else begin
            chk(rd_cap == e.data, {e.req, " R8"}, "read data", 32'(rd_cap), 32'(e.data));
            chk(oe_cap == 1'b1, {e.req, " R8"}, "read drive enable", 32'(oe_cap), 32'h1);
          end
        end
      end
    end
  end

  // driver: push expectation, run one backplane cycle
  task automatic vme_access(input logic [5:0] am, input logic [4:0] slot,
                            input logic [7:0] chip, input logic [9:0] rix,
                            input bit write, input logic [15:0] data,
                            input logic [1:0] ds, input bit expect_ok,
                            input bit split_release, input string req);
    int start;
    bit got;
    if (expect_ok) begin
      exp_t e;
      e.ce_n = ~chip; e.addr = rix; e.wr = write;
      e.data = write ? data : dev_model(~chip, rix);
      e.req = req;
      exp_q.push_back(e);
    end
    start = act_cycles;
    got = 1'b0;
    @(posedge clk); #1;
    vme_am = am; vme_addr = {slot, chip, rix}; vme_write_n = ~write;
    vme_data_in = data; vme_as_n = 1'b0; vme_ds_n = ds;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!vme_dtack_n) begin got = 1'b1; break; end
    end
    if (!expect_ok) begin
      chk(!got && act_cycles == start, req, "rejected cycle touched bus",
          32'(act_cycles - start), 32'd0);
    end else begin
      chk(got, req, "no dtack", 32'(got), 32'h1);
    end
    if (split_release) begin
      @(posedge clk); #1;
      vme_ds_n = 2'b01;
      repeat (3) @(negedge clk);
      chk(!vme_dtack_n && !(&bus_ce_n), "R9", "dtack held with one strobe low",
          32'(vme_dtack_n), 32'h0);
    end
    @(posedge clk); #1;
    vme_as_n = 1'b1; vme_ds_n = 2'b11;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, "expected cycle not seen", 32'(exp_q.size()), 32'd0);
    chk(vme_dtack_n && (&bus_ce_n) && !vme_data_oe, req, "bus not idle after cycle",
        {22'd0, vme_dtack_n, vme_data_oe, bus_ce_n}, 32'h2FF);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(vme_dtack_n && (&bus_ce_n) && !vme_data_oe, "R9", "reset state",
        {22'd0, vme_dtack_n, vme_data_oe, bus_ce_n}, 32'h2FF);

    // R2 R3 R4: single write to own slot
    vme_access(6'h39, 5'h0B, 8'h04, 10'h155, 1'b1, 16'hA5C3, 2'b00, 1'b1, 1'b0, "R4");
    // R8: single read
    vme_access(6'h3D, 5'h0B, 8'h80, 10'h2AA, 1'b0, 16'h0000, 2'b00, 1'b1, 1'b0, "R8");
    // R1: every accepted modifier
    for (int i = 0; i < 6; i++) begin
      logic [5:0] codes [6];
      codes = '{6'h39, 6'h3A, 6'h3B, 6'h3D, 6'h3E, 6'h3F};
      vme_access(codes[i], 5'h0B, 8'(1 << i), 10'(i * 37), 1'b1, 16'(16'h1000 + i),
                 2'b00, 1'b1, 1'b0, "R1");
    end
    // R1: rejected modifiers
    vme_access(6'h09, 5'h0B, 8'h01, 10'h001, 1'b1, 16'h1111, 2'b00, 1'b0, 1'b0, "R1");
    vme_access(6'h3C, 5'h0B, 8'h01, 10'h001, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, "R1");
    // R2: other slot
    vme_access(6'h39, 5'h0C, 8'h02, 10'h010, 1'b1, 16'h2222, 2'b00, 1'b0, 1'b0, "R2");
    // R5: multi-device write
    vme_access(6'h3A, 5'h0B, 8'hF0, 10'h3FF, 1'b1, 16'h5A5A, 2'b00, 1'b1, 1'b0, "R5");
    // R6: multi-device read rejected
    vme_access(6'h3A, 5'h0B, 8'h11, 10'h020, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, "R6");
    // R7: crate-wide write accepted, crate-wide read rejected
    vme_access(6'h3E, 5'h1F, 8'hFF, 10'h0C3, 1'b1, 16'hBEEF, 2'b00, 1'b1, 1'b0, "R7");
    vme_access(6'h3E, 5'h1F, 8'h01, 10'h0C3, 1'b0, 16'h0000, 2'b00, 1'b0, 1'b0, "R7");
    // R10: no device bit, single strobe
    vme_access(6'h39, 5'h0B, 8'h00, 10'h005, 1'b1, 16'h3333, 2'b00, 1'b0, 1'b0, "R10");
    vme_access(6'h39, 5'h0B, 8'h08, 10'h005, 1'b1, 16'h3333, 2'b10, 1'b0, 1'b0, "R10");
    // R9: one strobe released first
    vme_access(6'h3F, 5'h0B, 8'h20, 10'h111, 1'b0, 16'h0000, 2'b00, 1'b1, 1'b1, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule